// File: doc/BRIEF.md
# Page Buffer Programming Controller

This block stands between a byte-addressed programming port and a non-volatile memory whose page buffer is organised in 16-bit words. A command code held in a small register decides what a port access means. A read command turns each port read into a memory read. A load command turns each port write into a byte load into the page buffer. A write-page command turns a port write into a page program. The two erase commands do not use the port: an execute strobe starts them.

Bytes reach the word-wide buffer through a low-byte holding register. A write to an even address only fills the holding register. A write to the following odd address stores the held low byte and the new high byte into the buffer word in one cycle. Long operations (buffer erase, page erase, page write) sweep the page one word per cycle and then wait a configurable number of cycles. For that whole time a busy flag is raised and the port is stalled. Programming uses AND semantics: a bit can only change from 1 to 0.

Top module: `nvm_pgbuf_ctrl`

## Requirements
- R1: After reset, busy, port_stall and port_rvalid are low, the command is none, and every array byte and every buffer word reads as all ones.
- R2: Command codes are 0 none, 1 read, 2 erase buffer, 3 load buffer, 4 erase page, 5 write page. A command write is accepted only while idle. A port access under the none command has no effect and gives no port_rvalid.
- R3: A port read accepted under the read command makes port_rvalid high in the next cycle, with port_rdata holding the byte at that address. Byte address bit 0 selects the high byte of a word. Bits above it give the word, and the top bits give the page.
- R4: Under the load command, a port write with address bit 0 clear stores the byte in the holding register. A write with bit 0 set stores {new byte, held byte} into the buffer word selected by the address, in that cycle. The holding register keeps its value, so a high-byte write with no new low byte reuses the last held byte.
- R5: The execute strobe has no effect under the none, read, load and write-page commands.
- R6: The execute strobe under the erase-buffer command sets every buffer word to 16'hFFFF and the holding register to 8'hFF.
- R7: The execute strobe under the erase-page command sets every word of one page to 16'hFFFF. The page is the one addressed by the most recent accepted port access.
- R8: A port write under the write-page command programs the page that contains its address. Each word becomes the old word AND the buffer word.
- R9: Busy rises in the cycle after an operation is accepted. It stays high for exactly PAGE_WORDS + WAIT_CYCLES cycles.
- R10: port_stall follows busy. While busy is high, port accesses, command writes and execute strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 3 | New command code |
| exec_set | input | 1 | Execute strobe for the erase commands |
| port_req | input | 1 | Programming port access request |
| port_we | input | 1 | 1 = port write, 0 = port read |
| port_addr | input | ADDR_W | Byte address |
| port_wdata | input | 8 | Write byte |
| port_rdata | output | 8 | Read byte, registered |
| port_rvalid | output | 1 | port_rdata is valid this cycle |
| port_stall | output | 1 | Port must hold off its next access |
| busy | output | 1 | A long operation is running |

## Verification
A wrong word index or a holding register that is lost does not show when the byte is loaded. It only shows after the next page write, when the port reads back that word with the wrong byte. So every load pattern is followed by a full readback of the array. A sequencer that miscounts, or that lets an access through while busy, shows within one operation: the measured busy length is wrong, a stray command change is accepted, or a page that should be untouched is changed. The bench therefore measures every busy window and checks the whole array after each one.

// File: rtl/nvm_pkg.sv
// Package: shared command and operation codes for the page buffer controller.
// Assumes 3-bit command codes; any unlisted code behaves as "none".
package nvm_pkg;

    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_READ       = 3'd1,
        CMD_ERASE_BUF  = 3'd2,
        CMD_LOAD_BUF   = 3'd3,
        CMD_ERASE_PAGE = 3'd4,
        CMD_WRITE_PAGE = 3'd5
    } nvm_cmd_e;

    typedef enum logic [1:0] {
        OP_BUF_ERASE  = 2'd0,
        OP_PAGE_ERASE = 2'd1,
        OP_PAGE_WRITE = 2'd2
    } nvm_op_e;

endpackage

// File: rtl/nvm_seq.sv
// Module: long-operation sequencer.
// Raises busy for PAGE_WORDS sweep cycles followed by WAIT_CYCLES idle cycles.
// Each sweep cycle presents one word index. Assumes start is only pulsed while idle.
module nvm_seq #(
    parameter int PAGE_WORDS  = 64,
    parameter int WAIT_CYCLES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    output logic                          busy,
    output logic                          sweep_en,
    output logic [$clog2(PAGE_WORDS)-1:0] sweep_idx
);
    localparam int TOTAL = PAGE_WORDS + WAIT_CYCLES;
    localparam int CNT_W = $clog2(TOTAL) + 1;
    localparam int IDX_W = $clog2(PAGE_WORDS);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] SWEEP = CNT_W'(PAGE_WORDS);

    logic [CNT_W-1:0] cnt;

    // Count out one operation from acceptance to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Word index exposed during the sweep phase only.
    always_comb begin
        sweep_en  = busy && (cnt < SWEEP);
        sweep_idx = cnt[IDX_W-1:0];
    end

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != LAST) |=> busy); // R9
    AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cnt) == LAST); // R9
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R10

endmodule

// File: rtl/nvm_pgbuf.sv
// Module: word-organised page buffer with a low-byte holding register.
// Even-address byte writes fill the holding register. Odd-address writes commit
// {byte, held} into one word. The erase sweep clears one word per cycle.
// Assumes load and erase never coincide (load only while idle).
module nvm_pgbuf #(
    parameter int PAGE_WORDS = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_en,
    input  logic                          ld_hi,
    input  logic [$clog2(PAGE_WORDS)-1:0] ld_idx,
    input  logic [7:0]                    ld_data,
    input  logic                          clr_en,
    input  logic [$clog2(PAGE_WORDS)-1:0] clr_idx,
    input  logic [$clog2(PAGE_WORDS)-1:0] rd_idx,
    output logic [15:0]                   rd_word
);
    logic [15:0] words [PAGE_WORDS];
    logic [7:0]  hold_q;

    // Holding register: captures low bytes, returns to all ones on erase.
    always_ff @(posedge clk) begin
        if (!rst_n)                hold_q <= 8'hFF;
        else if (clr_en)           hold_q <= 8'hFF;
        else if (ld_en && !ld_hi)  hold_q <= ld_data;
    end

    // Buffer words: high-byte commit or sweep erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_WORDS; i++) words[i] <= 16'hFFFF;
        end else if (clr_en) begin
            words[clr_idx] <= 16'hFFFF;
        end else if (ld_en && ld_hi) begin
            words[ld_idx] <= {ld_data, hold_q};
        end
    end

    // Read port feeding the page-write sweep.
    always_comb rd_word = words[rd_idx];

    AST_HOLD_KEPT_ON_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_hi) |=> $stable(hold_q)); // R4
    AST_HOLD_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> hold_q == 8'hFF); // R6
    AST_LOAD_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_en && clr_en)); // R10

endmodule

// File: rtl/nvm_array.sv
// Module: synchronous memory array model.
// The sweep port erases a word or ANDs data into it. The read port returns one
// byte a cycle later. Assumes sweep and read never coincide.
module nvm_array #(
    parameter int PAGE_WORDS = 64,
    parameter int NUM_PAGES  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sw_en,
    input  logic                          sw_erase,
    input  logic [$clog2(NUM_PAGES)-1:0]  sw_page,
    input  logic [$clog2(PAGE_WORDS)-1:0] sw_idx,
    input  logic [15:0]                   sw_data,
    input  logic                          rd_en,
    input  logic [$clog2(PAGE_WORDS*NUM_PAGES)-1:0] rd_waddr,
    input  logic                          rd_hi,
    output logic [7:0]                    rd_byte,
    output logic                          rd_valid
);
    localparam int WORDS = PAGE_WORDS * NUM_PAGES;

    logic [15:0] mem [WORDS];
    logic [$clog2(WORDS)-1:0] sw_addr;

    always_comb sw_addr = {sw_page, sw_idx};

    // Array cells: erase to ones or program by AND.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
        end else if (sw_en) begin
            mem[sw_addr] <= sw_erase ? 16'hFFFF : (mem[sw_addr] & sw_data);
        end
    end

    // Registered byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_byte <= rd_hi ? mem[rd_waddr][15:8] : mem[rd_waddr][7:0];
        end
    end

    AST_RVALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en)); // R3
    AST_SWEEP_READ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_en && rd_en)); // R10

endmodule

// File: rtl/nvm_pgbuf_ctrl.sv
// Module: page buffer programming controller (top).
// Decodes the command register against port accesses and execute strobes.
// Starts long operations and stalls the port while they run.
// Assumes the port holds off while port_stall is high; any access it still
// presents then is dropped.
module nvm_pgbuf_ctrl #(
    parameter int PAGE_WORDS  = 64,
    parameter int NUM_PAGES   = 8,
    parameter int WAIT_CYCLES = 16,
    parameter int ADDR_W      = $clog2(PAGE_WORDS * NUM_PAGES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [2:0]        cmd_wdata,
    input  logic              exec_set,
    input  logic              port_req,
    input  logic              port_we,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [7:0]        port_wdata,
    output logic [7:0]        port_rdata,
    output logic              port_rvalid,
    output logic              port_stall,
    output logic              busy
);
    import nvm_pkg::*;

    localparam int IDX_W = $clog2(PAGE_WORDS);
    localparam int PG_W  = $clog2(NUM_PAGES);

    nvm_cmd_e          cmd_q;
    nvm_op_e           op_q;
    logic [PG_W-1:0]   last_page_q;
    logic [PG_W-1:0]   op_page_q;
    logic [PG_W-1:0]   addr_page;
    logic              acc, load_fire, wp_fire, rd_fire, ex_fire, start;
    logic              sweep_en;
    logic [IDX_W-1:0]  sweep_idx;
    logic [15:0]       buf_word;

    // Decode which action, if any, this cycle's inputs start.
    always_comb begin
        addr_page = port_addr[ADDR_W-1:IDX_W+1];
        acc       = port_req && !busy;
        load_fire = acc && port_we && (cmd_q == CMD_LOAD_BUF);
        wp_fire   = acc && port_we && (cmd_q == CMD_WRITE_PAGE);
        rd_fire   = acc && !port_we && (cmd_q == CMD_READ);
        ex_fire   = exec_set && !busy &&
                    (cmd_q == CMD_ERASE_BUF || cmd_q == CMD_ERASE_PAGE);
        start     = wp_fire || ex_fire;
        port_stall = busy;
    end

    // Command register, written only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)               cmd_q <= CMD_NONE;
        else if (cmd_we && !busy) cmd_q <= nvm_cmd_e'(cmd_wdata);
    end

    // Page of the latest accepted port access.
    always_ff @(posedge clk) begin
        if (!rst_n)   last_page_q <= '0;
        else if (acc) last_page_q <= addr_page;
    end

    // Operation kind and target page captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_BUF_ERASE;
            op_page_q <= '0;
        end else if (wp_fire) begin
            op_q      <= OP_PAGE_WRITE;
            op_page_q <= addr_page;
        end else if (ex_fire) begin
            op_q      <= (cmd_q == CMD_ERASE_BUF) ? OP_BUF_ERASE : OP_PAGE_ERASE;
            op_page_q <= last_page_q;
        end
    end

    nvm_seq #(.PAGE_WORDS(PAGE_WORDS), .WAIT_CYCLES(WAIT_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .sweep_en(sweep_en), .sweep_idx(sweep_idx)
    );

    nvm_pgbuf #(.PAGE_WORDS(PAGE_WORDS)) u_pgbuf (
        .clk(clk), .rst_n(rst_n),
        .ld_en(load_fire), .ld_hi(port_addr[0]), .ld_idx(port_addr[IDX_W:1]),
        .ld_data(port_wdata),
        .clr_en(sweep_en && op_q == OP_BUF_ERASE), .clr_idx(sweep_idx),
        .rd_idx(sweep_idx), .rd_word(buf_word)
    );

    nvm_array #(.PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES)) u_array (
        .clk(clk), .rst_n(rst_n),
        .sw_en(sweep_en && op_q != OP_BUF_ERASE),
        .sw_erase(op_q == OP_PAGE_ERASE),
        .sw_page(op_page_q), .sw_idx(sweep_idx), .sw_data(buf_word),
        .rd_en(rd_fire), .rd_waddr(port_addr[ADDR_W-1:1]), .rd_hi(port_addr[0]),
        .rd_byte(port_rdata), .rd_valid(port_rvalid)
    );

    AST_CMD_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q)); // R10
    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        port_rvalid |-> !$past(busy)); // R10
    AST_OP_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_page_q)); // R7

endmodule

// File: tb/nvm_pgbuf_ctrl_test.sv
// Bench: sweeps every byte of a small configuration against an arithmetic model.
module nvm_pgbuf_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 4;
    localparam int NP = 4;
    localparam int WT = 3;
    localparam int TOTAL = PW + WT;
    localparam int AW = $clog2(PW * NP) + 1;
    localparam int NBYTES = PW * NP * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_we = 1'b0;
    logic [2:0] cmd_wdata = 3'd0;
    logic exec_set = 1'b0;
    logic port_req = 1'b0;
    logic port_we = 1'b0;
    logic [AW-1:0] port_addr = '0;
    logic [7:0] port_wdata = 8'h00;
    logic [7:0] port_rdata;
    logic port_rvalid, port_stall, busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] mem_m [PW*NP];
    logic [15:0] buf_m [PW];
    logic [7:0]  hold_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_pgbuf_ctrl #(.PAGE_WORDS(PW), .NUM_PAGES(NP), .WAIT_CYCLES(WT)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .exec_set(exec_set), .port_req(port_req), .port_we(port_we),
        .port_addr(port_addr), .port_wdata(port_wdata), .port_rdata(port_rdata),
        .port_rvalid(port_rvalid), .port_stall(port_stall), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cmd(input logic [2:0] c);
        cmd_we = 1'b1; cmd_wdata = c;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic pulse_exec();
        exec_set = 1'b1;
        @(negedge clk);
        exec_set = 1'b0;
    endtask

    task automatic port_wr(input int a, input logic [7:0] d);
        port_req = 1'b1; port_we = 1'b1; port_addr = AW'(a); port_wdata = d;
        @(negedge clk);
        port_req = 1'b0; port_we = 1'b0;
    endtask

    task automatic port_rd(input int a, input string req);
        logic [15:0] w;
        logic [7:0]  e;
        port_req = 1'b1; port_we = 1'b0; port_addr = AW'(a);
        @(negedge clk);
        port_req = 1'b0;
        w = mem_m[a >> 1];
        e = a[0] ? w[15:8] : w[7:0];
        chk(port_rvalid === 1'b1, {req, " rvalid"}, int'(port_rvalid), 1);
        chk(port_rdata === e, req, int'(port_rdata), int'(e));
    endtask

    // Busy length from the first busy cycle to release; R9.
    task automatic wait_busy(input int expect_len);
        int n = 0;
        while (busy && n < 1000) begin
            chk(port_stall === 1'b1, "R10 stall", int'(port_stall), 1);
            n++;
            @(negedge clk);
        end
        chk(n == expect_len, "R9 busy length", n, expect_len);
    endtask

    task automatic read_all(input string req);
        set_cmd(3'd1);
        for (int a = 0; a < NBYTES; a++) port_rd(a, req);
    endtask

    task automatic load_pattern(input int k);
        set_cmd(3'd3);
        for (int w = 0; w < PW; w++) begin
            logic [15:0] v;
            v = 16'((k * 16'h3B17 + w * 16'h0F0F) ^ 16'hA5C3);
            port_wr(2 * w, v[7:0]);
            port_wr(2 * w + 1, v[15:8]);
            buf_m[w] = v;
            hold_m = v[7:0];
        end
    endtask

    task automatic model_write(input int p);
        for (int i = 0; i < PW; i++) mem_m[p*PW+i] = mem_m[p*PW+i] & buf_m[i];
    endtask

    initial begin
        for (int i = 0; i < PW*NP; i++) mem_m[i] = 16'hFFFF;
        for (int i = 0; i < PW; i++) buf_m[i] = 16'hFFFF;
        hold_m = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(busy === 1'b0, "R1 busy", int'(busy), 0);
        chk(port_stall === 1'b0, "R1 stall", int'(port_stall), 0);
        chk(port_rvalid === 1'b0, "R1 rvalid", int'(port_rvalid), 0);

        // R2: none command ignores accesses
        port_wr(3, 8'h00);
        chk(busy === 1'b0, "R2 none write", int'(busy), 0);
        port_req = 1'b1; port_addr = '0; @(negedge clk); port_req = 1'b0;
        chk(port_rvalid === 1'b0, "R2 none read", int'(port_rvalid), 0);
        read_all("R1 R3 reset array");

        // R5: execute ignored under read and load
        pulse_exec();
        chk(busy === 1'b0, "R5 exec under read", int'(busy), 0);
        set_cmd(3'd3);
        pulse_exec();
        chk(busy === 1'b0, "R5 exec under load", int'(busy), 0);

        // R6: erase buffer via execute
        set_cmd(3'd2);
        pulse_exec();
        chk(busy === 1'b1, "R9 busy rises", int'(busy), 1);
        wait_busy(TOTAL);

        // R4 R8: load a pattern and program page 2 via an address inside it
        load_pattern(1);
        set_cmd(3'd5);
        pulse_exec();
        chk(busy === 1'b0, "R5 exec under write page", int'(busy), 0);
        port_wr(2 * PW * 2 + 5, 8'h00);
        wait_busy(TOTAL);
        model_write(2);
        read_all("R8 page write");

        // R8: second program of the same page accumulates by AND
        load_pattern(2);
        set_cmd(3'd5);
        port_wr(2 * PW * 2, 8'h00);
        wait_busy(TOTAL);
        model_write(2);
        read_all("R8 AND program");

        // R4 R6: high-byte write reuses the held byte; after erase it is FF
        set_cmd(3'd2); pulse_exec(); wait_busy(TOTAL);
        for (int i = 0; i < PW; i++) buf_m[i] = 16'hFFFF;
        set_cmd(3'd3);
        port_wr(3, 8'h5A);            // word 1 high, held FF
        buf_m[1] = 16'h5AFF;
        port_wr(0, 8'h3C);            // word 0 low -> holding only
        port_wr(7, 8'hC1);            // word 3 high with held 3C
        buf_m[3] = 16'hC13C;
        port_wr(5, 8'h96);            // word 2 high, still held 3C
        buf_m[2] = 16'h963C;
        set_cmd(3'd5);
        port_wr(1 * PW * 2 + 1, 8'h00);
        wait_busy(TOTAL);
        model_write(1);
        read_all("R4 holding order");

        // R7: erase page chosen by last accepted access (read in page 2)
        set_cmd(3'd1);
        port_rd(2 * PW * 2 + 3, "R7 address latch");
        set_cmd(3'd4);
        pulse_exec();
        wait_busy(TOTAL);
        for (int i = 0; i < PW; i++) mem_m[2*PW+i] = 16'hFFFF;
        read_all("R7 page erase");

        // R10: accesses and command writes during busy are ignored
        load_pattern(3);
        set_cmd(3'd5);
        port_wr(0, 8'h00);            // program page 0
        model_write(0);
        chk(busy === 1'b1, "R10 busy", int'(busy), 1);
        cmd_we = 1'b1; cmd_wdata = 3'd1;
        port_req = 1'b1; port_we = 1'b1; port_addr = AW'(3 * PW * 2);
        @(negedge clk);
        cmd_we = 1'b0; port_req = 1'b0; port_we = 1'b0;
        wait_busy(TOTAL - 1);
        port_wr(3 * PW * 2 + 2, 8'h00);   // command must still be write page
        chk(busy === 1'b1, "R10 command kept", int'(busy), 1);
        wait_busy(TOTAL);
        model_write(3);
        read_all("R10 ignored during busy");

        // R10: second execute while busy does not extend the operation
        set_cmd(3'd2);
        pulse_exec();
        pulse_exec();
        wait_busy(TOTAL - 1);
        chk(busy === 1'b0, "R10 exec ignored", int'(busy), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule